// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Framing-Error Flag

This block is the receive half of a classic microcontroller-style serial port. It watches a serial input line, oversampled by an enable pulse that fires a fixed number of times per bit. It checks each start bit and assembles each frame into a parallel byte. It reports completion through a receive-done flag held in an 8-bit control register, which has the usual single-write, always-readable bus access.

Two frame formats are supported. In the 8-bit format a start bit is followed by eight data bits, least significant first, and one stop bit. In the two 9-bit formats a tag bit follows the eighth data bit. The tag bit can gate reception for address filtering in multi-drop links. The stop bit is always checked, and a low stop bit sets a framing-error flag that stays set until software clears it.

A view-select input decides what the top bit of the control register means. With the input low, that bit is the upper format-select bit. With the input high, it is the framing-error flag, and in the 9-bit formats the receive-done flag is then delayed to the stop bit so that error and completion are reported together.

Top module: `serial_rx_fe`

## Requirements
- R1: After reset the control register reads 0x00, the received byte reads 0, and both the receive-done and framing-error outputs are low.
- R2: A frame is one start bit (0), eight data bits least significant first, then a tag bit in the 9-bit formats, then one stop bit. Format select is {bit 7, bit 6} of the control register: 01 is the 8-bit format, and 10 or 11 is a 9-bit format. An accepted byte appears on `rx_byte` when the receive-done flag (bit 0) rises, and `rx_byte` changes at no other time.
- R3: Reception starts only on a high-to-low transition of the line. The start bit is then confirmed by a majority vote of three samples at the bit centre. A low pulse shorter than half a bit returns the receiver to idle and produces no byte.
- R4: With `err_view` high, bit 7 reads and writes the framing-error flag. With `err_view` low, it reads and writes the upper format-select bit. A write made in the error view leaves the format-select bit unchanged.
- R5: When a stop bit is sampled as 0, the framing-error flag and the `frame_err` output are set, in any receive format and in either view.
- R6: The framing-error flag is not cleared by a later valid stop bit. Only a write of 0 to bit 7 with `err_view` high clears it.
- R7: In the 9-bit formats with `err_view` low, the receive-done flag rises while the tag bit is still on the line.
- R8: In the 8-bit format in either view, and in the 9-bit formats with `err_view` high, the receive-done flag rises while the stop bit is on the line.
- R9: In the 9-bit formats an accepted frame copies its tag bit into bit 2 of the control register.
- R10: With bit 5 set in a 9-bit format, a frame whose tag bit is 0 does not load the byte and does not raise the receive-done flag. A frame whose tag bit is 1 is accepted.
- R11: While the receive-done flag is still set, a newly received frame is dropped and `rx_byte` keeps the earlier byte.
- R12: No frame is received when bit 4 (receiver enable) is 0, or when the format select is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, OVS pulses per bit time |
| rxd | input | 1 | Serial input line, idle high |
| err_view | input | 1 | Selects the framing-error view of control bit 7 |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| rx_byte | output | DW | Last accepted received byte |
| rx_done | output | 1 | Receive-done flag (control bit 0) |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
A bit-counter or shift fault shows up on `rx_byte` at the receive-done rise of the same frame, so it is caught within one frame time. A wrong acceptance point is seen as the receive-done rise falling in the wrong bit period, which the monitor compares against the bit the driver is currently sending. A corrupted view mux or a shared storage bit shows up in the control read-back as soon as the view is switched after a framing error. A lost error flag shows up on `frame_err` right after the next clean frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_NINTH,
      ST_STOP
   } rx_state_e;

   localparam int unsigned B_MODE_HI = 7;
   localparam int unsigned B_MODE_LO = 6;
   localparam int unsigned B_FILT    = 5;
   localparam int unsigned B_REN     = 4;
   localparam int unsigned B_TX9     = 3;
   localparam int unsigned B_RX9     = 2;
   localparam int unsigned B_TXF     = 1;
   localparam int unsigned B_RXF     = 0;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= (sr << 1) | STAGES'(d);
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic busy,
   input  logic start,
   input  logic din,
   output logic mid_stb,
   output logic mid_bit
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] S0   = CW'(OVS/2 - 1);
   localparam logic [CW-1:0] S1   = CW'(OVS/2);
   localparam logic [CW-1:0] S2   = CW'(OVS/2 + 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   logic [CW-1:0] cnt;
   logic [1:0]    early;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         early <= '0;
      end else if (start) begin
         cnt <= CW'(1);
      end else if (!busy) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         if (cnt == S0) early[0] <= din;
         if (cnt == S1) early[1] <= din;
      end
   end

   assign mid_stb = busy && tick && (cnt == S2);
   assign mid_bit = (early[0] & early[1]) | (early[0] & din) | (early[1] & din);
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
   import serial_rx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          din,
   input  logic          armed,
   input  logic          nine_in,
   input  logic          mid_stb,
   input  logic          mid_bit,
   output logic          busy,
   output logic          start,
   output logic [DW-1:0] data,
   output logic          nine_q,
   output logic          nbit_q,
   output logic          ev_ninth,
   output logic          ev_stop
);
   localparam int IW = $clog2(DW);
   localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

   rx_state_e     st;
   logic [IW-1:0] idx;
   logic          last_din;

   assign busy     = (st != ST_IDLE);
   assign start    = (st == ST_IDLE) && armed && tick && last_din && !din;
   assign ev_ninth = mid_stb && (st == ST_NINTH);
   assign ev_stop  = mid_stb && (st == ST_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         idx      <= '0;
         data     <= '0;
         nine_q   <= 1'b0;
         nbit_q   <= 1'b0;
         last_din <= 1'b1;
      end else begin
         if (tick) last_din <= din;
         if (start) begin
            st     <= ST_START;
            nine_q <= nine_in;
         end else if (mid_stb) begin
            unique case (st)
               ST_START: begin
                  st  <= mid_bit ? ST_IDLE : ST_DATA;
                  idx <= '0;
               end
               ST_DATA: begin
                  data <= {mid_bit, data[DW-1:1]};
                  idx  <= idx + 1'b1;
                  if (idx == LAST_IDX) st <= nine_q ? ST_NINTH : ST_STOP;
               end
               ST_NINTH: begin
                  nbit_q <= mid_bit;
                  st     <= ST_STOP;
               end
               ST_STOP:  st <= ST_IDLE;
               default:  st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_rx_fe.sv
module serial_rx_fe
   import serial_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          os_tick,
   input  logic          rxd,
   input  logic          err_view,
   input  logic          reg_we,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   output logic [DW-1:0] rx_byte,
   output logic          rx_done,
   output logic          frame_err
);
   if (OVS < 4) begin : g_bad_ovs
      $error("serial_rx_fe: OVS must be at least 4");
   end
   if (DW < 2) begin : g_bad_dw
      $error("serial_rx_fe: DW must be at least 2");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("serial_rx_fe: SYNC_STAGES must not be negative");
   end

   logic          din, busy, start, mid_stb, mid_bit;
   logic          nine_q, nbit_q, ev_ninth, ev_stop;
   logic [DW-1:0] data;

   logic mode_hi_q, mode_lo_q, err_q, filt_q, ren_q, tx9_q, rx9_q, txf_q, rxf_q;
   logic [DW-1:0] buf_q;

   logic armed, take, tag_bit, accept, bad_stop;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(din)
   );

   serial_rx_sampler #(.OVS(OVS)) u_sampler (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .busy(busy), .start(start),
      .din(din), .mid_stb(mid_stb), .mid_bit(mid_bit)
   );

   serial_rx_framer #(.DW(DW)) u_framer (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .din(din), .armed(armed),
      .nine_in(mode_hi_q), .mid_stb(mid_stb), .mid_bit(mid_bit),
      .busy(busy), .start(start), .data(data), .nine_q(nine_q),
      .nbit_q(nbit_q), .ev_ninth(ev_ninth), .ev_stop(ev_stop)
   );

   assign armed    = ren_q && (mode_hi_q || mode_lo_q);
   assign take     = (nine_q && !err_view) ? ev_ninth : ev_stop;
   assign tag_bit  = (nine_q && !err_view) ? mid_bit : nbit_q;
   assign accept   = take && !rxf_q && (!(nine_q && filt_q) || tag_bit);
   assign bad_stop = ev_stop && !mid_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_hi_q <= 1'b0; mode_lo_q <= 1'b0; err_q <= 1'b0;
         filt_q    <= 1'b0; ren_q     <= 1'b0; tx9_q <= 1'b0;
         rx9_q     <= 1'b0; txf_q     <= 1'b0; rxf_q <= 1'b0;
         buf_q     <= '0;
      end else begin
         if (reg_we) begin
            if (err_view) err_q     <= reg_wdata[B_MODE_HI];
            else          mode_hi_q <= reg_wdata[B_MODE_HI];
            mode_lo_q <= reg_wdata[B_MODE_LO];
            filt_q    <= reg_wdata[B_FILT];
            ren_q     <= reg_wdata[B_REN];
            tx9_q     <= reg_wdata[B_TX9];
            rx9_q     <= reg_wdata[B_RX9];
            txf_q     <= reg_wdata[B_TXF];
            rxf_q     <= reg_wdata[B_RXF];
         end
         if (accept) begin
            buf_q <= data;
            rxf_q <= 1'b1;
            if (nine_q) rx9_q <= tag_bit;
         end
         if (bad_stop) err_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata            = '0;
      reg_rdata[B_MODE_HI] = err_view ? err_q : mode_hi_q;
      reg_rdata[B_MODE_LO] = mode_lo_q;
      reg_rdata[B_FILT]    = filt_q;
      reg_rdata[B_REN]     = ren_q;
      reg_rdata[B_TX9]     = tx9_q;
      reg_rdata[B_RX9]     = rx9_q;
      reg_rdata[B_TXF]     = txf_q;
      reg_rdata[B_RXF]     = rxf_q;
   end

   assign rx_byte   = buf_q;
   assign rx_done   = rxf_q;
   assign frame_err = err_q;
endmodule

// File: rtl/serial_rx_fe_chk.sv
module serial_rx_fe_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic          err_view,
   input logic [7:0]    reg_wdata,
   input logic [7:0]    reg_rdata,
   input logic [DW-1:0] rx_byte,
   input logic          rx_done,
   input logic          frame_err,
   input logic          mode_hi_q
);
   // R6
   fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_err) |-> $past(reg_we && err_view && !reg_wdata[7]));

   // R4
   mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && err_view) |=> $stable(mode_hi_q));

   // R2
   buf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_byte) |-> $rose(rx_done));

   // R11
   overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rx_done) && !$past(reg_we)) |-> $stable(rx_byte));

   // R12
   ren_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_done) && !$past(reg_we)) |-> $past(reg_rdata[4]));

   // R10
   filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_done) && !$past(reg_we) && $past(reg_rdata[5]) && $past(mode_hi_q))
      |-> reg_rdata[2]);
endmodule

bind serial_rx_fe serial_rx_fe_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .err_view(err_view),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_byte(rx_byte),
   .rx_done(rx_done), .frame_err(frame_err), .mode_hi_q(mode_hi_q)
);

// File: tb/serial_rx_fe_test.sv
module serial_rx_fe_test;
   localparam int CLK_PERIOD = 10;
   localparam int OVS        = 16;
   localparam int TDIV       = 2;
   localparam int BIT_CYC    = OVS * TDIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       err_view = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] rx_byte;
   logic       rx_done, frame_err;

   serial_rx_fe #(.OVS(OVS), .DW(8), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
      .err_view(err_view), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rx_byte(rx_byte), .rx_done(rx_done),
      .frame_err(frame_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int divcnt = 0;
   always @(negedge clk) begin
      if (divcnt == TDIV - 1) begin divcnt <= 0; os_tick <= 1'b1; end
      else begin divcnt <= divcnt + 1; os_tick <= 1'b0; end
   end

   typedef struct {
      logic [7:0] b;
      logic       nine;
      logic       tag;
      int         ph;
      string      req;
   } exp_t;

   exp_t       exp_q[$];
   int         n_cmp = 0;
   int         n_bad = 0;
   int         cur_phase = -1;
   bit         done_flag = 0;
   logic [7:0] sh = '0;
   logic [7:0] last_byte = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // monitor: pops one expected item on every receive-done rise
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n && rx_done && !prev_done) begin
         if (exp_q.size() == 0) begin
            check(0, "R10", "unexpected receive-done rise", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(rx_byte == e.b, "R2", "received byte", rx_byte, e.b);
            check(cur_phase == e.ph, e.req, "bit period of receive-done rise", cur_phase, e.ph);
            if (e.nine) check(reg_rdata[2] == e.tag, "R9", "captured tag bit", reg_rdata[2], e.tag);
         end
      end
      prev_done = rx_done;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      finish_run();
   end

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic setup(input bit hi, input bit lo, input bit filt, input bit ren);
      bit v;
      v = err_view;
      sh = {hi, lo, filt, ren, 4'b0000};
      err_view = 1'b0;
      wr(sh);
      err_view = v;
   endtask

   task automatic clr_done();
      setup(sh[7], sh[6], sh[5], sh[4]);
   endtask

   task automatic send(input logic [7:0] b, input bit nine, input bit tag,
                       input bit stop_ok, input bit expect_rx, input int ph,
                       input string req);
      if (expect_rx) begin
         exp_t e;
         e.b = b; e.nine = nine; e.tag = tag; e.ph = ph; e.req = req;
         exp_q.push_back(e);
         last_byte = b;
      end
      @(negedge clk);
      rxd = 1'b0; cur_phase = 0;
      repeat (BIT_CYC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i]; cur_phase = i + 1;
         repeat (BIT_CYC) @(negedge clk);
      end
      if (nine) begin
         rxd = tag; cur_phase = 9;
         repeat (BIT_CYC) @(negedge clk);
      end
      rxd = stop_ok; cur_phase = 10;
      repeat (BIT_CYC) @(negedge clk);
      rxd = 1'b1; cur_phase = -1;
      repeat (BIT_CYC) @(negedge clk);
      check(exp_q.size() == 0, req, "expected frames still pending", exp_q.size(), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(reg_rdata == 8'h00, "R1", "control after reset", reg_rdata, 0);
      check(rx_done == 1'b0, "R1", "receive-done after reset", rx_done, 0);
      check(frame_err == 1'b0, "R1", "frame error after reset", frame_err, 0);
      check(rx_byte == 8'h00, "R1", "byte after reset", rx_byte, 0);

      // R8: 8-bit format, done at stop bit in both views
      setup(0, 1, 0, 1);
      send(8'hA5, 0, 0, 1, 1, 10, "R8"); clr_done();
      send(8'h3C, 0, 0, 1, 1, 10, "R8"); clr_done();
      err_view = 1'b1;
      send(8'h81, 0, 0, 1, 1, 10, "R8"); clr_done();
      err_view = 1'b0;

      // R7: 9-bit format, plain view, done during tag bit
      setup(1, 0, 0, 1);
      send(8'h5A, 1, 1, 1, 1, 9, "R7"); clr_done();
      send(8'h0F, 1, 0, 1, 1, 9, "R7"); clr_done();

      // R8: 9-bit format, error view, done at stop bit
      setup(1, 1, 0, 1);
      err_view = 1'b1;
      send(8'hC3, 1, 1, 1, 1, 10, "R8"); clr_done();
      send(8'h12, 1, 0, 1, 1, 10, "R8"); clr_done();

      // R5 / R6 / R4: bad stop, stickiness, view separation
      send(8'h77, 1, 1, 0, 1, 10, "R5");
      check(frame_err == 1'b1, "R5", "flag after bad stop", frame_err, 1);
      check(reg_rdata[7] == 1'b1, "R4", "bit 7 in error view", reg_rdata[7], 1);
      clr_done();
      send(8'h66, 1, 0, 1, 1, 10, "R6"); clr_done();
      check(frame_err == 1'b1, "R6", "flag after clean frame", frame_err, 1);
      err_view = 1'b0;
      @(negedge clk);
      check(reg_rdata[7] == 1'b1, "R4", "format bit in plain view", reg_rdata[7], 1);
      err_view = 1'b1;
      wr({1'b0, sh[6:0]});
      @(negedge clk);
      check(frame_err == 1'b0, "R6", "flag after clearing write", frame_err, 0);
      err_view = 1'b0;
      @(negedge clk);
      check(reg_rdata[7] == 1'b1, "R4", "format bit kept by error-view write", reg_rdata[7], 1);

      // R5 in the 8-bit format with plain view
      setup(0, 1, 0, 1);
      send(8'h2D, 0, 0, 0, 1, 10, "R5"); clr_done();
      check(frame_err == 1'b1, "R5", "flag after bad stop, 8-bit", frame_err, 1);
      err_view = 1'b1;
      wr({1'b0, sh[6:0]});
      err_view = 1'b0;

      // R10: tag filter
      setup(1, 0, 1, 1);
      send(8'h44, 1, 0, 1, 0, 9, "R10");
      check(rx_done == 1'b0, "R10", "done with tag 0 filtered", rx_done, 0);
      check(rx_byte == last_byte, "R10", "byte kept with tag 0", rx_byte, last_byte);
      send(8'h99, 1, 1, 1, 1, 9, "R10"); clr_done();

      // R11: overrun drop
      setup(0, 1, 0, 1);
      send(8'h11, 0, 0, 1, 1, 10, "R11");
      send(8'h22, 0, 0, 1, 0, 10, "R11");
      check(rx_byte == 8'h11, "R11", "byte kept while done set", rx_byte, 8'h11);
      clr_done();

      // R12: receiver disabled, and format 00
      setup(0, 1, 0, 0);
      send(8'h33, 0, 0, 1, 0, 10, "R12");
      check(rx_done == 1'b0, "R12", "done with enable off", rx_done, 0);
      setup(0, 0, 0, 1);
      send(8'h34, 0, 0, 1, 0, 10, "R12");
      check(rx_byte == last_byte, "R12", "byte kept in format 00", rx_byte, last_byte);

      // R3: short low glitch rejected, next frame received
      setup(0, 1, 0, 1);
      @(negedge clk);
      rxd = 1'b0;
      repeat (4 * TDIV) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BIT_CYC) @(negedge clk);
      check(rx_done == 1'b0, "R3", "done after glitch", rx_done, 0);
      check(rx_byte == last_byte, "R3", "byte after glitch", rx_byte, last_byte);
      send(8'h5E, 0, 0, 1, 1, 10, "R3"); clr_done();

      finish_run();
   end
endmodule